// File: doc/BRIEF.md
# Windowed Direct-Mapped Read Cache

This block sits between a 32-bit core and a single-word memory port. It keeps recently read data in a one-way, direct-mapped store. Each line holds `LINE_WORDS` words (4 or 8), and the total capacity `CACHE_BYTES` may be set from 64 bytes to 64 KB. Tags and line data sit in synchronous-read RAM arrays. One valid bit is held per line.

Only addresses between `WIN_BASE` and `WIN_HIGH`, both ends included, can hit or allocate. They do so only while the `cache_en` input (the enable bit from the machine status register) is high. Every other access goes to memory as a single-word transaction.

Writes go through to memory every time. A write also updates the cached word if it hits, and it never allocates a line. A read miss fetches the whole line, starting at word 0, and returns the requested word once the last word has arrived. Software can drop one line with an invalidate command that carries an address. After reset, the block clears every valid bit in one pass over the index range, and it holds off the core until that pass is done.

Top module: `wcache_top`

## Requirements
- R1: After reset the block clears one line's valid bit per cycle over all `CACHE_BYTES/(4*LINE_WORDS)` lines and raises no `cpu_ack` until the pass completes; a request held during the pass is served afterwards as a miss.
- R2: A read with `cpu_op`=0 to a cacheable address that misses issues exactly `LINE_WORDS` memory reads, at the line base plus 4*k for k = 0, 1, … in that order, then acknowledges with the word at the requested address.
- R3: A read hit returns the cached word on `cpu_ack` two cycles after the request is accepted, with no memory request.
- R4: Cacheable means `WIN_BASE` <= address <= `WIN_HIGH`. A read outside that range makes one memory read at the exact address and allocates nothing, so repeating it reads memory again.
- R5: While `cache_en` is low every read bypasses the cache with one memory read. Lines already cached stay valid and hit again once `cache_en` is high.
- R6: A write (`cpu_op`=1) makes exactly one memory write carrying the request address and data. On a hit it also updates the cached word, so a later read hits and returns the new data.
- R7: A write that misses leaves the line stored at that index untouched.
- R8: An invalidate (`cpu_op[1]`=1) clears the valid bit of the line indexed by the request address, whatever its tag. It is acknowledged one cycle after acceptance with no memory traffic.
- R9: A memory request keeps `mem_req` high and `mem_addr` unchanged until `mem_ack`.
- R10: `cpu_ack` is a one-cycle pulse. The core holds `cpu_req` and its fields until it sees that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Cache enable bit from the status register |
| cpu_req | input | 1 | Core request, held until `cpu_ack` |
| cpu_op | input | 2 | 0 read, 1 write, 2 or 3 invalidate line |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench reads the middle of a line and checks the order of the fetch addresses and the word returned. A fill that started at the requested word, or that answered before the line was complete, would return the wrong word or break the address order. It probes the window edges (`WIN_BASE`-4, `WIN_HIGH`-3 and `WIN_HIGH`+1). An off-by-one comparison would then allocate a line outside the window or bypass an address inside it.

A write miss to a line that shares an index with a cached line must leave that line alone. Allocating on the write, or clearing the line, would turn the next read into a fill. An invalidate given with a different tag must still drop the line, since a tag-qualified invalidate would leave a hit behind. Toggling `cache_en` must bypass without losing the lines already cached.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_MEM
  } wc_state_t;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;

  // Extract n bits of a starting at bit lo.
  function automatic logic [31:0] fn_field(logic [31:0] a, int lo, int n);
    return (a >> lo) & ((32'd1 << n) - 32'd1);
  endfunction

  // Inclusive cacheable-window test.
  function automatic logic fn_in_window(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Rebuild a byte address from tag, index and word number.
  function automatic logic [31:0] fn_line_addr(logic [31:0] tag, logic [31:0] idx,
                                               logic [31:0] word, int off_w, int idx_w);
    return (tag << (off_w + idx_w)) | (idx << off_w) | (word << 2);
  endfunction

endpackage

// File: rtl/wcache_ram.sv
module wcache_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/wcache_valid.sv
module wcache_valid #(
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             init_done
);

  logic [IDX_W-1:0] sweep_idx;
  logic [SETS-1:0]  bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_idx <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (sweep_idx == IDX_W'(SETS - 1)) init_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : g_line
    wire wipe = (!init_done && sweep_idx == IDX_W'(g)) ||
                (clr_en && clr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wipe)                                  bits[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))   bits[g] <= 1'b1;
    end
  end

  assign rd_valid = bits[rd_idx];

endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
#(
  parameter int          LINE_WORDS = 4,
  parameter int          SETS       = 16,
  parameter logic [31:0] WIN_BASE   = 32'h0000_1000,
  parameter logic [31:0] WIN_HIGH   = 32'h0000_1FFF,
  localparam int WOFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = WOFF_W + 2,
  localparam int TAG_W  = 32 - OFF_W - IDX_W,
  localparam int DA_W   = IDX_W + WOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              init_done,
  input  logic              line_valid,
  output logic [IDX_W-1:0]  vld_idx,
  output logic              vld_set,
  output logic              vld_clr,
  output logic [IDX_W-1:0]  clr_idx,
  output logic [IDX_W-1:0]  tag_raddr,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  input  logic [TAG_W-1:0]  tag_rdata,
  output logic [DA_W-1:0]   dat_raddr,
  output logic              dat_we,
  output logic [DA_W-1:0]   dat_waddr,
  output logic [31:0]       dat_wdata,
  input  logic [31:0]       dat_rdata,
  output logic              ev_hit,
  output logic              ev_wr_hit,
  output logic              ev_miss,
  output logic              ev_bypass,
  output logic              ev_fill_done
);

  wc_state_t         st;
  logic [1:0]        q_op;
  logic [31:0]       q_addr, q_wdata;
  logic [WOFF_W-1:0] cnt;

  wire [IDX_W-1:0]  q_idx  = IDX_W'(fn_field(q_addr, OFF_W, IDX_W));
  wire [WOFF_W-1:0] q_word = WOFF_W'(fn_field(q_addr, 2, WOFF_W));
  wire [TAG_W-1:0]  q_tag  = TAG_W'(q_addr >> (OFF_W + IDX_W));
  wire              q_wr   = (q_op == OP_WRITE);
  wire cacheable = cache_en && fn_in_window(q_addr, WIN_BASE, WIN_HIGH);
  wire hit       = cacheable && line_valid && (tag_rdata == q_tag);
  wire last_beat = (cnt == WOFF_W'(LINE_WORDS - 1));
  wire idle_take = (st == ST_IDLE) && cpu_req;
  wire take_inv  = idle_take && cpu_op[1];

  assign ev_hit       = (st == ST_LOOK) && hit && !q_wr;
  assign ev_wr_hit    = (st == ST_LOOK) && hit && q_wr;
  assign ev_miss      = (st == ST_LOOK) && cacheable && !hit;
  assign ev_bypass    = (st == ST_LOOK) && !cacheable;
  assign ev_fill_done = (st == ST_FILL) && mem_ack && last_beat;

  // RAM read ports follow the incoming request so data is ready in ST_LOOK.
  assign tag_raddr = IDX_W'(fn_field(cpu_addr, OFF_W, IDX_W));
  assign dat_raddr = DA_W'(fn_field(cpu_addr, 2, DA_W));
  assign vld_idx   = q_idx;
  assign clr_idx   = tag_raddr;
  assign vld_clr   = take_inv;
  assign vld_set   = ev_fill_done;
  assign tag_we    = ev_fill_done;
  assign tag_wdata = q_tag;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = q_addr;
    mem_wdata = q_wdata;
    dat_we    = 1'b0;
    dat_waddr = {q_idx, q_word};
    dat_wdata = q_wdata;
    case (st)
      ST_LOOK: dat_we = ev_wr_hit;
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_addr  = fn_line_addr(32'(q_tag), 32'(q_idx), 32'(cnt), OFF_W, IDX_W);
        dat_we    = mem_ack;
        dat_waddr = {q_idx, cnt};
        dat_wdata = mem_rdata;
      end
      ST_MEM: begin
        mem_req = 1'b1;
        mem_we  = q_wr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      q_op      <= OP_READ;
      q_addr    <= '0;
      q_wdata   <= '0;
      cnt       <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      case (st)
        ST_INIT: if (init_done) st <= ST_IDLE;
        ST_IDLE: if (cpu_req) begin
          q_op    <= cpu_op;
          q_addr  <= cpu_addr;
          q_wdata <= cpu_wdata;
          if (cpu_op[1]) cpu_ack <= 1'b1;
          else           st      <= ST_LOOK;
        end
        ST_LOOK: begin
          cnt <= '0;
          if (q_wr) st <= ST_MEM;
          else if (hit) begin
            cpu_rdata <= dat_rdata;
            cpu_ack   <= 1'b1;
            st        <= ST_IDLE;
          end else if (cacheable) st <= ST_FILL;
          else                    st <= ST_MEM;
        end
        ST_FILL: if (mem_ack) begin
          if (cnt == q_word) cpu_rdata <= mem_rdata;
          if (last_beat) begin
            cpu_ack <= 1'b1;
            st      <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_MEM: if (mem_ack) begin
          if (!q_wr) cpu_rdata <= mem_rdata;
          cpu_ack <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wcache_top.sv
module wcache_top #(
  parameter int          LINE_WORDS  = 4,
  parameter int          CACHE_BYTES = 256,
  parameter logic [31:0] WIN_BASE    = 32'h0000_1000,
  parameter logic [31:0] WIN_HIGH    = 32'h0000_1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        cpu_req,
  input  logic [1:0]  cpu_op,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ack,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  localparam int WORDS  = CACHE_BYTES / 4;
  localparam int SETS   = WORDS / LINE_WORDS;
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = WOFF_W + 2;
  localparam int TAG_W  = 32 - OFF_W - IDX_W;
  localparam int DA_W   = IDX_W + WOFF_W;

  logic             init_done, line_valid, vld_set, vld_clr;
  logic [IDX_W-1:0] vld_idx, clr_idx, tag_raddr;
  logic             tag_we, dat_we;
  logic [TAG_W-1:0] tag_wdata, tag_rdata;
  logic [DA_W-1:0]  dat_raddr, dat_waddr;
  logic [31:0]      dat_wdata, dat_rdata;
  logic             ev_hit, ev_wr_hit, ev_miss, ev_bypass, ev_fill_done;

  wcache_ctrl #(
    .LINE_WORDS(LINE_WORDS), .SETS(SETS), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH)
  ) u_ctrl (
    .clk, .rst_n, .cache_en, .cpu_req, .cpu_op, .cpu_addr, .cpu_wdata,
    .cpu_ack, .cpu_rdata, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_ack, .mem_rdata, .init_done, .line_valid, .vld_idx, .vld_set,
    .vld_clr, .clr_idx, .tag_raddr, .tag_we, .tag_wdata, .tag_rdata,
    .dat_raddr, .dat_we, .dat_waddr, .dat_wdata, .dat_rdata,
    .ev_hit, .ev_wr_hit, .ev_miss, .ev_bypass, .ev_fill_done
  );

  wcache_valid #(.SETS(SETS)) u_valid (
    .clk, .rst_n,
    .set_en(vld_set), .set_idx(vld_idx),
    .clr_en(vld_clr), .clr_idx(clr_idx),
    .rd_idx(vld_idx), .rd_valid(line_valid), .init_done(init_done)
  );

  wcache_ram #(.W(TAG_W), .DEPTH(SETS)) u_tags (
    .clk, .we(tag_we), .waddr(vld_idx), .wdata(tag_wdata),
    .raddr(tag_raddr), .rdata(tag_rdata)
  );

  wcache_ram #(.W(32), .DEPTH(WORDS)) u_data (
    .clk, .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata),
    .raddr(dat_raddr), .rdata(dat_rdata)
  );

endmodule

// File: rtl/wcache_chk.sv
module wcache_chk #(
  parameter int OFF_W      = 4,
  parameter int LINE_WORDS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ack,
  input logic        init_done,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        ev_hit,
  input logic        ev_wr_hit,
  input logic        ev_miss,
  input logic        ev_bypass,
  input logic        ev_fill_done
);

  assert_stall_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !cpu_ack);

  assert_fill_ends_last_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |-> (32'(mem_addr[OFF_W-1:2]) == 32'(LINE_WORDS - 1)));

  assert_hit_answers_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> cpu_ack);

  assert_single_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hit, ev_wr_hit, ev_miss, ev_bypass}));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

endmodule

bind wcache_top wcache_chk #(.OFF_W(OFF_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk, .rst_n, .cpu_ack, .init_done, .mem_req, .mem_ack, .mem_addr,
  .ev_hit, .ev_wr_hit, .ev_miss, .ev_bypass, .ev_fill_done
);

// File: tb/sim_wcache_top.sv
`timescale 1ns/1ps
module sim_wcache_top;

  localparam int SETS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  wcache_top u0 (.*);

  int n_chk = 0, n_fail = 0;
  int rd_n = 0, wr_n = 0;
  logic [31:0] rd_log [8];
  logic [31:0] last_wa, last_wd;
  logic [31:0] bmem [4096];

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  initial for (int i = 0; i < 4096; i++) bmem[i] = pat(32'(i) << 2);

  // Memory model: one-cycle acknowledge per word.
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        bmem[mem_addr[13:2]] <= mem_wdata;
        wr_n    <= wr_n + 1;
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
      end else begin
        mem_rdata <= bmem[mem_addr[13:2]];
        if (rd_n < 8) rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual run length %0d expected below 100000", wd);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_op = op; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk); @(negedge clk); cyc++;
    end while (!cpu_ack);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic t_reset_and_fill();
    logic [31:0] rd; int cyc, r0;
    chk("R1 ack low in reset", 32'(cpu_ack), 0);
    r0 = rd_n;
    @(negedge clk); rst_n = 1'b1;
    access(2'd0, 32'h0000_1008, 0, rd, cyc);
    chk("R1 stalled through init pass", 32'(cyc > SETS), 1);
    chk("R2 fill beat count", 32'(rd_n - r0), 4);
    for (int k = 0; k < 4; k++)
      chk("R2 fill order", rd_log[r0 + k], 32'h0000_1000 + 32'(4 * k));
    chk("R2 requested word", rd, pat(32'h0000_1008));
  endtask

  task automatic t_hit();
    logic [31:0] rd; int cyc, r0;
    r0 = rd_n;
    access(2'd0, 32'h0000_100C, 0, rd, cyc);
    chk("R3 hit data", rd, pat(32'h0000_100C));
    chk("R3 hit latency", 32'(cyc), 2);
    chk("R3 hit no memory", 32'(rd_n - r0), 0);
  endtask

  task automatic t_window();
    logic [31:0] rd; int cyc, r0;
    r0 = rd_n;
    access(2'd0, 32'h0000_3004, 0, rd, cyc);
    access(2'd0, 32'h0000_3004, 0, rd, cyc);
    chk("R4 outside reads memory each time", 32'(rd_n - r0), 2);
    chk("R4 outside exact address", rd_log[r0 + 1], 32'h0000_3004);
    chk("R4 outside data", rd, pat(32'h0000_3004));
    r0 = rd_n;
    access(2'd0, 32'h0000_0FFC, 0, rd, cyc);
    chk("R4 below base bypass", 32'(rd_n - r0), 1);
    r0 = rd_n;
    access(2'd0, 32'h0000_1FFC, 0, rd, cyc);
    chk("R4 top word of window allocates", 32'(rd_n - r0), 4);
    r0 = rd_n;
    access(2'd0, 32'h0000_2000, 0, rd, cyc);
    chk("R4 above high bypass", 32'(rd_n - r0), 1);
    chk("R4 above high data", rd, pat(32'h0000_2000));
  endtask

  task automatic t_disable();
    logic [31:0] rd; int cyc, r0;
    cache_en = 1'b0;
    r0 = rd_n;
    access(2'd0, 32'h0000_1008, 0, rd, cyc);
    chk("R5 disabled bypass", 32'(rd_n - r0), 1);
    chk("R5 disabled data", rd, pat(32'h0000_1008));
    cache_en = 1'b1;
    r0 = rd_n;
    access(2'd0, 32'h0000_1008, 0, rd, cyc);
    chk("R5 line kept after re-enable", 32'(rd_n - r0), 0);
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc, r0, w0;
    w0 = wr_n;
    access(2'd1, 32'h0000_1004, 32'hCAFE_0001, rd, cyc);
    chk("R6 one memory write", 32'(wr_n - w0), 1);
    chk("R6 write address", last_wa, 32'h0000_1004);
    chk("R6 write data", last_wd, 32'hCAFE_0001);
    r0 = rd_n;
    access(2'd0, 32'h0000_1004, 0, rd, cyc);
    chk("R6 hit after write", 32'(rd_n - r0), 0);
    chk("R6 updated word", rd, 32'hCAFE_0001);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int cyc, r0, w0;
    w0 = wr_n;
    access(2'd1, 32'h0000_1404, 32'hBEEF_0002, rd, cyc);
    chk("R7 write miss passes through", 32'(wr_n - w0), 1);
    r0 = rd_n;
    access(2'd0, 32'h0000_1000, 0, rd, cyc);
    chk("R7 resident line untouched", 32'(rd_n - r0), 0);
    access(2'd0, 32'h0000_1404, 0, rd, cyc);
    chk("R7 no allocate on write", 32'(rd_n - r0), 4);
    chk("R7 memory holds written word", rd, 32'hBEEF_0002);
  endtask

  task automatic t_invalidate();
    logic [31:0] rd; int cyc, r0, w0;
    r0 = rd_n; w0 = wr_n;
    access(2'd2, 32'h0000_1000, 0, rd, cyc);
    chk("R8 invalidate latency", 32'(cyc), 1);
    chk("R8 no memory traffic", 32'((rd_n - r0) + (wr_n - w0)), 0);
    access(2'd0, 32'h0000_1408, 0, rd, cyc);
    chk("R8 line refilled", 32'(rd_n - r0), 4);
    chk("R10 refill data", rd, pat(32'h0000_1408));
    @(negedge clk);
    chk("R10 ack single pulse", 32'(cpu_ack), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_fill();
    t_hit();
    t_window();
    t_disable();
    t_write_hit();
    t_write_miss();
    t_invalidate();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule